// File: doc/BRIEF.md
# CRC-16 Memory Integrity Checker

This block watches a region of read-only memory for unintended change. For each run the caller gives a start address, a byte count and a 16-bit seed. The block reads the region one byte per cycle through a synchronous read port and folds every byte into a CRC-16 signature.

Whether a run captures or compares depends on an internal reference flag. After reset the flag is 0x00. The first accepted run stores its signature as the golden reference and sets the flag to 0xFF. Every later run compares its fresh signature against that reference and reports pass or fail. A run whose start address or length is odd is refused at once and the memory is never touched.

Top module: `crc16_mem_checker`

## Requirements
- R1: Each byte is folded MSB first in 8 shift steps. The generator is 0x8005 (x^16+x^15+x^2+1). There is no input or output reflection and no final XOR. The finished signature stays on crc_o after done_o.
- R2: At every accepted start the CRC register is loaded from seed_i, so two runs over the same data with different seeds give the signatures a model predicts for each seed.
- R3: A run issues exactly length_i read requests on ascending addresses starting at start_addr_i. The read data is taken one cycle after each request.
- R4: On a run finishing while ref_flag_o is 0x00, the signature is stored, ref_flag_o becomes 0xFF, and captured_o pulses with done_o while pass_o and fail_o stay low.
- R5: On a run finishing while ref_flag_o is 0xFF, pass_o pulses with done_o if the signature equals the stored reference.
- R6: On a mismatch, fail_o pulses with done_o and the reference is kept unchanged, so a later run over restored data passes.
- R7: A start with start_addr_i[0] or length_i[0] set gives done_o with align_err_o one cycle later. It makes no read, never raises busy_o and leaves ref_flag_o unchanged.
- R8: busy_o is high from the cycle after an accepted start until done_o. done_o is a one-cycle pulse. A start while busy_o is high is ignored, and a start in the cycle done_o is high is accepted.
- R9: After reset busy_o, done_o, all status outputs and mem_req_o are low and ref_flag_o is 0x00.
- R10: A zero-length run makes no reads and finishes with crc_o equal to the seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Launch pulse |
| start_addr_i | input | AW | First byte address, must be even |
| length_i | input | LW | Byte count, must be even |
| seed_i | input | 16 | CRC start value |
| mem_req_o | output | 1 | Read request |
| mem_addr_o | output | AW | Read address |
| mem_rdata_i | input | 8 | Read data, valid one cycle after request |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Signature matched the reference |
| fail_o | output | 1 | Signature differed from the reference |
| captured_o | output | 1 | Reference was captured by this run |
| align_err_o | output | 1 | Odd address or length was refused |
| ref_flag_o | output | 8 | 0x00 no reference, 0xFF reference held |
| crc_o | output | 16 | Last computed signature |

## Verification
The completion of one run and the launch of the next can fall in the same cycle: a start pulse may be sampled on the very edge at which done_o and its status are visible. The bench drives start_i in the cycle it sees done_o. It then judges that the first run's status is intact, that the second run makes its full set of reads, and that the second run reports its own result. Back-to-back refused starts are also sent, so that done_o on consecutive cycles is covered.

// File: rtl/crc_chk_pkg.sv
package crc_chk_pkg;
  localparam logic [15:0] CRC_POLY   = 16'h8005;
  localparam logic [7:0]  FLAG_EMPTY = 8'h00;
  localparam logic [7:0]  FLAG_SET   = 8'hFF;

  typedef enum logic {ST_IDLE, ST_RUN} chk_state_e;

  function automatic logic [15:0] crc_fold(logic [15:0] crc, logic [7:0] data);
    logic [15:0] c;
    logic        fb;
    c = crc;
    for (int i = 7; i >= 0; i--) begin
      fb = c[15] ^ data[i];
      c  = {c[14:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction
endpackage

// File: rtl/chk_addr_seq.sv
module chk_addr_seq #(
  parameter int AW = 16,
  parameter int LW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] base_i,
  input  logic [LW-1:0] len_i,
  input  logic          en_i,
  output logic          req_o,
  output logic [AW-1:0] addr_o,
  output logic          empty_o
);
  logic [LW-1:0] left_q;
  logic [AW-1:0] addr_q;

  assign req_o   = en_i && (left_q != '0);
  assign empty_o = (left_q == '0);
  assign addr_o  = addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q <= '0;
      addr_q <= '0;
    end else if (load_i) begin
      left_q <= len_i;
      addr_q <= base_i;
    end else if (req_o) begin
      left_q <= left_q - LW'(1);
      addr_q <= addr_q + AW'(1);
    end
  end

  AST_ADDR_ASCENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && $past(req_o)) |-> (addr_o == AW'($past(addr_o) + AW'(1)))); // R3
  AST_REQ_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> en_i); // R7
endmodule

// File: rtl/chk_crc_engine.sv
module chk_crc_engine
  import crc_chk_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        load_i,
  input  logic [15:0] seed_i,
  input  logic        fold_i,
  input  logic [7:0]  byte_i,
  output logic [15:0] crc_o
);
  logic [15:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= '0;
    else if (load_i) crc_q <= seed_i;
    else if (fold_i) crc_q <= crc_fold(crc_q, byte_i);
  end

  assign crc_o = crc_q;

  AST_SEED_LOADED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (crc_o == $past(seed_i))); // R2
endmodule

// File: rtl/chk_ref_store.sv
module chk_ref_store
  import crc_chk_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        commit_i,
  input  logic [15:0] sig_i,
  output logic [7:0]  flag_o,
  output logic        match_o
);
  logic [15:0] ref_q;
  logic [7:0]  flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q  <= '0;
      flag_q <= FLAG_EMPTY;
    end else if (commit_i && flag_q == FLAG_EMPTY) begin
      ref_q  <= sig_i;
      flag_q <= FLAG_SET;
    end
  end

  assign flag_o  = flag_q;
  assign match_o = (ref_q == sig_i);

  AST_FLAG_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o == FLAG_EMPTY) || (flag_o == FLAG_SET)); // R4
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o == FLAG_SET) |=> (flag_o == FLAG_SET)); // R6
  AST_REF_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o == FLAG_SET) |=> $stable(ref_q)); // R6
endmodule

// File: rtl/crc16_mem_checker.sv
module crc16_mem_checker
  import crc_chk_pkg::*;
#(
  parameter int AW = 16,
  parameter int LW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] start_addr_i,
  input  logic [LW-1:0] length_i,
  input  logic [15:0]   seed_i,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic [7:0]    mem_rdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          pass_o,
  output logic          fail_o,
  output logic          captured_o,
  output logic          align_err_o,
  output logic [7:0]    ref_flag_o,
  output logic [15:0]   crc_o
);
  chk_state_e state_q;
  logic accept, odd, launch, reject, finish;
  logic rvalid_q, seq_empty, match;

  assign accept = start_i && (state_q == ST_IDLE);
  assign odd    = start_addr_i[0] | length_i[0];
  assign launch = accept && !odd;
  assign reject = accept && odd;
  assign finish = (state_q == ST_RUN) && seq_empty && !rvalid_q;

  chk_addr_seq #(.AW(AW), .LW(LW)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (launch),
    .base_i  (start_addr_i),
    .len_i   (length_i),
    .en_i    (state_q == ST_RUN),
    .req_o   (mem_req_o),
    .addr_o  (mem_addr_o),
    .empty_o (seq_empty)
  );

  chk_crc_engine u_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (launch),
    .seed_i (seed_i),
    .fold_i (rvalid_q),
    .byte_i (mem_rdata_i),
    .crc_o  (crc_o)
  );

  chk_ref_store u_ref (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .commit_i (finish),
    .sig_i    (crc_o),
    .flag_o   (ref_flag_o),
    .match_o  (match)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      rvalid_q    <= 1'b0;
      done_o      <= 1'b0;
      pass_o      <= 1'b0;
      fail_o      <= 1'b0;
      captured_o  <= 1'b0;
      align_err_o <= 1'b0;
    end else begin
      rvalid_q    <= mem_req_o;
      done_o      <= finish || reject;
      align_err_o <= reject;
      captured_o  <= finish && (ref_flag_o == FLAG_EMPTY);
      pass_o      <= finish && (ref_flag_o == FLAG_SET) && match;
      fail_o      <= finish && (ref_flag_o == FLAG_SET) && !match;
      if (launch)      state_q <= ST_RUN;
      else if (finish) state_q <= ST_IDLE;
    end
  end

  assign busy_o = (state_q == ST_RUN);

  AST_REQ_ONLY_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o); // R7
  AST_PASS_FAIL_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pass_o && fail_o)); // R5
  AST_STATUS_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pass_o || fail_o || captured_o || align_err_o) |-> done_o); // R8
  AST_CAPTURE_SETS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    captured_o |-> (ref_flag_o == FLAG_SET)); // R4
  AST_BUSY_ENDS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o); // R8
  AST_ERR_NO_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    align_err_o |-> !busy_o); // R7
endmodule

// File: tb/crc16_mem_checker_tb.sv
module crc16_mem_checker_tb;
  localparam int AW = 16;
  localparam int LW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [LW-1:0] length = '0;
  logic [15:0]   seed = '0;
  logic          mem_req;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_rdata = '0;
  logic          busy, done, pass, fail, captured, align_err;
  logic [7:0]    ref_flag;
  logic [15:0]   crc;

  always #5 clk = ~clk;

  crc16_mem_checker #(.AW(AW), .LW(LW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .start_addr_i(start_addr),
    .length_i(length), .seed_i(seed), .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rdata_i(mem_rdata), .busy_o(busy), .done_o(done), .pass_o(pass),
    .fail_o(fail), .captured_o(captured), .align_err_o(align_err),
    .ref_flag_o(ref_flag), .crc_o(crc)
  );

  logic [7:0] mem [256];
  int total = 0, bad = 0, req_total = 0, addr_bad = 0, snap = 0;
  logic [AW-1:0] run_base = '0;
  bit finished = 0;

  always @(posedge clk) begin
    if (mem_req) begin
      mem_rdata <= mem[mem_addr[7:0]];
      if (mem_addr != AW'(run_base + AW'(req_total - snap))) addr_bad++;
      req_total++;
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] model(logic [15:0] s, int base, int len);
    logic [15:0] c = s;
    for (int b = 0; b < len; b++) begin
      for (int i = 7; i >= 0; i--) begin
        logic fb = c[15] ^ mem[(base + b) & 255][i];
        c = {c[14:0], 1'b0} ^ (fb ? 16'h8005 : 16'h0000);
      end
    end
    return c;
  endfunction

  // run results
  bit r_busy_bad, r_pass, r_fail, r_cap, r_err;
  int r_reads;

  task automatic launch(int a, int l, logic [15:0] s);
    @(negedge clk);
    start_addr = AW'(a); length = LW'(l); seed = s;
    run_base = AW'(a); snap = req_total; addr_bad = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(bit want_busy);
    r_busy_bad = 0;
    for (int c = 0; c < 2000; c++) begin
      if (done) break;
      if (want_busy && !busy) r_busy_bad = 1;
      @(negedge clk);
    end
    r_pass = pass; r_fail = fail; r_cap = captured; r_err = align_err;
    r_reads = req_total - snap;
    chk(done, "R8 done seen", done, 1);
  endtask

  task automatic t_reset();
    chk(!busy && !done && !mem_req, "R9 idle outputs", {busy, done, mem_req}, 0);
    chk(!pass && !fail && !captured && !align_err, "R9 status low",
        {pass, fail, captured, align_err}, 0);
    chk(ref_flag == 8'h00, "R9 flag", ref_flag, 0);
  endtask

  task automatic t_odd();
    launch(8'h21, 16, 16'hFFFF);
    chk(done && align_err && !busy, "R7 odd addr refused", {done, align_err, busy}, 3'b110);
    chk(req_total == snap, "R7 no reads", req_total - snap, 0);
    @(negedge clk);
    chk(!done, "R8 done one cycle", done, 0);
    // back-to-back refusals: done on consecutive cycles
    start_addr = 16'h20; length = 16'd15; start = 1'b1;
    @(negedge clk);
    chk(done && align_err, "R7 odd length refused", {done, align_err}, 2'b11);
    start_addr = 16'h23; length = 16'd4;
    @(negedge clk);
    start = 1'b0;
    chk(done && align_err && !busy, "R7 odd again", {done, align_err, busy}, 3'b110);
    chk(ref_flag == 8'h00 && req_total == snap, "R7 flag and reads kept", ref_flag, 0);
  endtask

  task automatic t_capture();
    launch(8'h20, 16, 16'hFFFF);
    chk(busy, "R8 busy after start", busy, 1);
    wait_done(1);
    chk(!r_busy_bad, "R8 busy held", r_busy_bad, 0);
    chk(r_cap && !r_pass && !r_fail, "R4 captured", {r_cap, r_pass, r_fail}, 3'b100);
    chk(ref_flag == 8'hFF, "R4 flag set", ref_flag, 8'hFF);
    chk(crc == model(16'hFFFF, 8'h20, 16), "R1 signature", crc, model(16'hFFFF, 8'h20, 16));
    chk(r_reads == 16 && addr_bad == 0, "R3 reads", r_reads, 16);
    @(negedge clk);
    chk(!done && !busy, "R8 done pulse", {done, busy}, 0);
    chk(crc == model(16'hFFFF, 8'h20, 16), "R1 crc held", crc, model(16'hFFFF, 8'h20, 16));
  endtask

  task automatic t_pass();
    launch(8'h20, 16, 16'hFFFF);
    wait_done(1);
    chk(r_pass && !r_fail && !r_cap, "R5 pass", {r_pass, r_fail, r_cap}, 3'b100);
  endtask

  task automatic t_seed();
    launch(8'h20, 16, 16'h1D0F);
    wait_done(1);
    chk(crc == model(16'h1D0F, 8'h20, 16), "R2 seeded crc", crc, model(16'h1D0F, 8'h20, 16));
    chk(r_fail && !r_pass, "R6 seed mismatch fails", {r_fail, r_pass}, 2'b10);
  endtask

  task automatic t_corrupt();
    mem[8'h25] = mem[8'h25] ^ 8'h10;
    launch(8'h20, 16, 16'hFFFF);
    wait_done(1);
    chk(r_fail && !r_pass, "R6 corrupt fails", {r_fail, r_pass}, 2'b10);
    mem[8'h25] = mem[8'h25] ^ 8'h10;
    launch(8'h20, 16, 16'hFFFF);
    wait_done(1);
    chk(r_pass && !r_fail, "R6 ref unchanged", {r_pass, r_fail}, 2'b10);
  endtask

  task automatic t_zero();
    launch(8'h40, 0, 16'h1234);
    wait_done(1);
    chk(crc == 16'h1234, "R10 crc equals seed", crc, 16'h1234);
    chk(r_reads == 0, "R10 no reads", r_reads, 0);
  endtask

  task automatic t_busy_ignore();
    launch(8'h20, 16, 16'hFFFF);
    @(negedge clk); @(negedge clk);
    start_addr = 16'h40; length = 16'd4; seed = 16'h0000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(1);
    chk(r_pass && r_reads == 16 && addr_bad == 0, "R8 start while busy ignored",
        r_reads, 16);
  endtask

  task automatic t_back2back();
    launch(8'h20, 16, 16'hFFFF);
    wait_done(1);
    chk(r_pass, "R8 first of pair passes", r_pass, 1);
    start_addr = 16'h30; length = 16'd8; seed = 16'hFFFF;
    run_base = 16'h30; snap = req_total; addr_bad = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && !done, "R8 start at done accepted", {busy, done}, 2'b10);
    wait_done(1);
    chk(r_fail && r_reads == 8 && addr_bad == 0, "R8 second run own result", r_reads, 8);
    chk(crc == model(16'hFFFF, 8'h30, 8), "R3 second signature", crc,
        model(16'hFFFF, 8'h30, 8));
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'((i * 37 + 5) ^ (i >> 3));
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_odd();
    t_capture();
    t_pass();
    t_seed();
    t_corrupt();
    t_zero();
    t_busy_ignore();
    t_back2back();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule